// File: doc/BRIEF.md
# Chained Timebase Synchronisation Controller

This block sets the timing role of one card in a chain of cards joined output-to-input by a single synchronisation wire. It runs on a local clock of eight samples per microsecond and watches the incoming line. It measures the period and the high time of each cycle on that line and sorts it into one of three kinds: a reference symbol (about 62.5 % high), a plain 1 MHz clock (40–60 % high), or a reset symbol (12.5 % high). Anything else counts as an invalid period. From the class it has settled on, and from two configuration inputs, it reports whether the card is a slave and whether the timebase is running from an internal reference.

Every card keeps a 64-bit counter that steps once per microsecond. It is read as two 32-bit words. A counter reset can be requested locally, or it can arrive as a reset symbol from upstream. Either one clears the counter, drives a one-sample active-low strobe and sets a sticky done flag. A master answers a local request by placing a reset symbol on its output, so that the cards downstream clear in step. A slave copies its input to its output, one sample late, so reset symbols coming from upstream pass on down the chain. An 8-bit oscillator trim value is only held in a register.

Top module: `tsync_ctrl`

## Requirements
- R1: The counter starts at 0. It steps by exactly one every 8 samples, counting from the clock edge at which a reset event is registered. That edge makes the counter 0, and the count is floor(k/8) at k edges after it. The high word is `cnt_hi`, the low word is `cnt_lo`.
- R2: With `ref_sel`=1 and `sys_sel`=0, a settled class of reference symbol gives `is_slave`=1 and `int_ref`=0.
- R3: With `ref_sel`=1 and `sys_sel`=0, a settled class of nothing gives `is_slave`=0 and `int_ref`=1. This is the class after reset.
- R4: With `ref_sel`=1 and `sys_sel`=0, a settled class of plain clock gives `is_slave`=0 and `int_ref`=0. As a master, the card drives reference symbols on `sync_out`, which are high runs of exactly 5 samples.
- R5: `sys_sel`=1 forces `is_slave`=0 and `int_ref`=0. The content of `sync_in`, reset symbols included, then has no effect.
- R6: A period is valid only if it lasts 7 to 9 samples, measured from one rising edge to the next. A valid period with 1–2 high samples is a reset symbol, with 3–4 high samples a clock, and with 5–6 high samples a reference symbol. Any other period is invalid. A valid clock or reference period sets the settled class at once.
- R7: The settled class falls back to nothing only after 4 invalid periods in a row. A stretch of 9 samples with no rising edge counts as one invalid period.
- R8: `rst_req` on a master clears the counter and pulls `strobe_n` low for exactly one sample on the next edge. The next full output period is then a reset symbol: a 1-sample high run on `sync_out`.
- R9: `rst_req` on a slave clears the counter and pulses `strobe_n`, but adds no reset symbol to `sync_out`.
- R10: A slave that receives a reset symbol clears its counter, pulses `strobe_n` once and relays the symbol. While the card is a slave, `sync_out` equals `sync_in` delayed by one sample.
- R11: `sync_done` is set by every reset event and cleared by `done_clr`. When both happen in the same cycle, the set wins.
- R12: `cal_q` loads `cal_din` when `cal_we`=1 and holds its value otherwise.
- R13: `ref_sel`=0 makes the card a master with `int_ref`=1, whatever arrives on `sync_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sample clock, 8 samples per microsecond |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Sampled incoming chain line |
| ref_sel | input | 1 | 1: take the reference from the chain input |
| sys_sel | input | 1 | 1: system clock is the reference, card is always master |
| rst_req | input | 1 | Counter reset request, one cycle |
| done_clr | input | 1 | Clears the sticky done flag |
| cal_we | input | 1 | Load strobe for the trim byte |
| cal_din | input | 8 | New trim value |
| sync_out | output | 1 | Outgoing chain line |
| strobe_n | output | 1 | Active-low one-sample reset strobe |
| is_slave | output | 1 | Card is a slave |
| int_ref | output | 1 | Timebase runs on the internal reference |
| sync_done | output | 1 | Sticky flag: a counter reset has happened |
| cal_q | output | 8 | Held trim value |
| cnt_hi | output | 32 | Upper word of the microsecond counter |
| cnt_lo | output | 32 | Lower word of the microsecond counter |

## Verification
The hardest case to reach is a reset symbol arriving at a card that is already a slave. This needs a run of reference periods long enough to settle the class, followed by one period that is 12.5 % high. The bench produces it with a background line driver that runs a repeating pattern of programmable period and high time and can swap a single reset period into the stream. The checks then count strobe samples and the 1-sample high runs on the relayed output. Loss of the class is reached by stopping the line and sampling once before the fourth invalid period and once after it.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
    typedef enum logic [1:0] {
        SC_NONE = 2'd0,
        SC_CLK  = 2'd1,
        SC_REF  = 2'd2,
        SC_RST  = 2'd3
    } sym_cls_e;
endpackage

// File: rtl/tsync_meas.sv
// Measures each period of the incoming line between rising edges and
// classifies it by high-sample count; flags missing edges as invalid.
module tsync_meas
    import tsync_pkg::*;
#(
    parameter int SPP = 8,
    parameter int TOL = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_i,
    output logic     ev_o,
    output sym_cls_e cls_o
);
    localparam int PW = $clog2(SPP + TOL + 2);
    localparam logic [PW-1:0] PER_LO = PW'(SPP - TOL);
    localparam logic [PW-1:0] PER_HI = PW'(SPP + TOL);
    localparam logic [PW-1:0] RST_LO = PW'(SPP / 8);
    localparam logic [PW-1:0] RST_HI = PW'(SPP / 8 + TOL);
    localparam logic [PW-1:0] CLK_LO = PW'(SPP * 2 / 5);
    localparam logic [PW-1:0] CLK_HI = PW'(SPP * 3 / 5);
    localparam logic [PW-1:0] REF_LO = PW'(SPP * 5 / 8);
    localparam logic [PW-1:0] REF_HI = PW'(SPP * 5 / 8 + TOL);

    typedef struct packed {
        logic          prev;
        logic [PW-1:0] per;
        logic [PW-1:0] hi;
        logic          ev;
        sym_cls_e      cls;
    } meas_t;

    meas_t q, d;

    function automatic sym_cls_e classify(input logic [PW-1:0] per, input logic [PW-1:0] hi);
        if (per < PER_LO || per > PER_HI)      return SC_NONE;
        else if (hi >= RST_LO && hi <= RST_HI) return SC_RST;
        else if (hi >= CLK_LO && hi <= CLK_HI) return SC_CLK;
        else if (hi >= REF_LO && hi <= REF_HI) return SC_REF;
        else                                   return SC_NONE;
    endfunction

    always_comb begin
        d      = q;
        d.prev = line_i;
        d.ev   = 1'b0;
        d.cls  = SC_NONE;
        if (line_i && !q.prev) begin
            d.ev  = 1'b1;
            d.cls = classify(q.per, q.hi);
            d.per = PW'(1);
            d.hi  = PW'(1);
        end else if (q.per == PER_HI) begin
            d.ev  = 1'b1;
            d.cls = SC_NONE;
            d.per = PW'(1);
            d.hi  = '0;
        end else begin
            d.per = q.per + PW'(1);
            d.hi  = q.hi + {{(PW-1){1'b0}}, line_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{prev: 1'b0, per: '0, hi: '0, ev: 1'b0, cls: SC_NONE};
        else        q <= d;
    end

    assign ev_o  = q.ev;
    assign cls_o = q.cls;
endmodule

// File: rtl/tsync_track.sv
// Holds the settled line class; drops it after LOSS invalid periods in a row.
module tsync_track
    import tsync_pkg::*;
#(
    parameter int LOSS = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ev_i,
    input  sym_cls_e ev_cls_i,
    output sym_cls_e cls_o,
    output logic     rst_hit_o
);
    localparam int LW = $clog2(LOSS + 1);
    localparam logic [LW-1:0] LAST_BAD = LW'(LOSS - 1);

    typedef struct packed {
        sym_cls_e      cls;
        logic [LW-1:0] bad;
    } trk_t;

    trk_t q, d;

    always_comb begin
        d = q;
        if (ev_i) begin
            if (ev_cls_i == SC_NONE) begin
                if (q.bad == LAST_BAD) d.cls = SC_NONE;
                else                   d.bad = q.bad + LW'(1);
            end else begin
                d.bad = '0;
                if (ev_cls_i != SC_RST) d.cls = ev_cls_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{cls: SC_NONE, bad: '0};
        else        q <= d;
    end

    assign cls_o     = q.cls;
    assign rst_hit_o = ev_i && (ev_cls_i == SC_RST) && (q.cls == SC_REF);
endmodule

// File: rtl/tsync_gen.sv
// Produces reference symbols; an armed request turns the next full period
// into a reset symbol.
module tsync_gen #(
    parameter int SPP = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic bit_o
);
    localparam int PHW = $clog2(SPP);
    localparam logic [PHW:0] LAST  = (PHW+1)'(SPP - 1);
    localparam logic [PHW:0] REF_N = (PHW+1)'(SPP * 5 / 8);
    localparam logic [PHW:0] RST_N = (PHW+1)'(SPP / 8);

    typedef struct packed {
        logic [PHW:0] phase;
        logic         pend;
        logic         rsym;
    } gen_t;

    gen_t q, d;

    always_comb begin
        d = q;
        if (q.phase == LAST) begin
            d.phase = '0;
            d.rsym  = q.pend | arm_i;
            d.pend  = 1'b0;
        end else begin
            d.phase = q.phase + 1'b1;
            d.pend  = q.pend | arm_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_o = q.phase < (q.rsym ? RST_N : REF_N);
endmodule

// File: rtl/tsync_timebase.sv
// Microsecond counter built from a sample prescaler.
module tsync_timebase #(
    parameter int SPP = 8,
    parameter int CW  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    localparam int PRW = $clog2(SPP);
    localparam logic [PRW-1:0] PRE_LAST = PRW'(SPP - 1);

    typedef struct packed {
        logic [CW-1:0]  cnt;
        logic [PRW-1:0] pre;
    } tb_t;

    tb_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.cnt = '0;
            d.pre = '0;
        end else if (q.pre == PRE_LAST) begin
            d.pre = '0;
            d.cnt = q.cnt + CW'(1);
        end else begin
            d.pre = q.pre + PRW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o = q.cnt;
endmodule

// File: rtl/tsync_ctrl.sv
module tsync_ctrl
    import tsync_pkg::*;
#(
    parameter int SPP  = 8,
    parameter int TOL  = 1,
    parameter int LOSS = 4,
    parameter int CW   = 64,
    parameter int CALW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_in,
    input  logic            ref_sel,
    input  logic            sys_sel,
    input  logic            rst_req,
    input  logic            done_clr,
    input  logic            cal_we,
    input  logic [CALW-1:0] cal_din,
    output logic            sync_out,
    output logic            strobe_n,
    output logic            is_slave,
    output logic            int_ref,
    output logic            sync_done,
    output logic [CALW-1:0] cal_q,
    output logic [CW/2-1:0] cnt_hi,
    output logic [CW/2-1:0] cnt_lo
);
    typedef struct packed {
        logic            sout;
        logic            stb_n;
        logic            done;
        logic [CALW-1:0] cal;
    } top_t;

    top_t q, d;

    logic          ev;
    sym_cls_e      ev_cls;
    sym_cls_e      cls;
    logic          rst_hit;
    logic          gen_bit;
    logic          slave;
    logic          hit;
    logic          arm;
    logic [CW-1:0] cnt;

    tsync_meas #(.SPP(SPP), .TOL(TOL)) u_meas (
        .clk(clk), .rst_n(rst_n), .line_i(sync_in), .ev_o(ev), .cls_o(ev_cls)
    );

    tsync_track #(.LOSS(LOSS)) u_track (
        .clk(clk), .rst_n(rst_n), .ev_i(ev), .ev_cls_i(ev_cls),
        .cls_o(cls), .rst_hit_o(rst_hit)
    );

    tsync_gen #(.SPP(SPP)) u_gen (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .bit_o(gen_bit)
    );

    tsync_timebase #(.SPP(SPP), .CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .clr_i(hit), .cnt_o(cnt)
    );

    always_comb begin
        slave   = ref_sel && !sys_sel && (cls == SC_REF);
        int_ref = !sys_sel && (!ref_sel || (cls == SC_NONE));
        hit     = rst_req || (slave && rst_hit);
        arm     = rst_req && !slave;

        d       = q;
        d.sout  = slave ? sync_in : gen_bit;
        d.stb_n = !hit;
        d.done  = hit || (q.done && !done_clr);
        if (cal_we) d.cal = cal_din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{sout: 1'b0, stb_n: 1'b1, done: 1'b0, cal: '0};
        else        q <= d;
    end

    assign sync_out  = q.sout;
    assign strobe_n  = q.stb_n;
    assign sync_done = q.done;
    assign cal_q     = q.cal;
    assign is_slave  = slave;
    assign cnt_hi    = cnt[CW-1:CW/2];
    assign cnt_lo    = cnt[CW/2-1:0];
endmodule

// File: rtl/tsync_chk.sv
module tsync_chk #(
    parameter int HW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_in,
    input logic          sys_sel,
    input logic          rst_req,
    input logic          sync_out,
    input logic          strobe_n,
    input logic          is_slave,
    input logic          int_ref,
    input logic          sync_done,
    input logic [HW-1:0] cnt_lo
);
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |=> strobe_n);

    a_r8_req_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !strobe_n);

    a_r1_zero_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> (cnt_lo == '0));

    a_r1_step_or_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_lo) |-> ((cnt_lo == $past(cnt_lo) + 1'b1) || (cnt_lo == '0)));

    a_r11_done_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> sync_done);

    a_r10_slave_relay: assert property (@(posedge clk) disable iff (!rst_n)
        is_slave |=> (sync_out == $past(sync_in)));

    a_r2_slave_not_internal: assert property (@(posedge clk) disable iff (!rst_n)
        is_slave |-> !int_ref);

    a_r5_system_master: assert property (@(posedge clk) disable iff (!rst_n)
        sys_sel |-> (!is_slave && !int_ref));
endmodule

bind tsync_ctrl tsync_chk #(.HW(CW/2)) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sys_sel(sys_sel),
    .rst_req(rst_req), .sync_out(sync_out), .strobe_n(strobe_n),
    .is_slave(is_slave), .int_ref(int_ref), .sync_done(sync_done),
    .cnt_lo(cnt_lo)
);

// File: tb/tb_tsync_ctrl.sv
`timescale 1ns/1ps
module tb_tsync_ctrl;
    logic        clk = 1'b0;
    logic        rst_n, sync_in, ref_sel, sys_sel, rst_req, done_clr, cal_we;
    logic [7:0]  cal_din;
    logic        sync_out, strobe_n, is_slave, int_ref, sync_done;
    logic [7:0]  cal_q;
    logic [31:0] cnt_hi, cnt_lo;

    always #2.5 clk = ~clk;

    tsync_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .ref_sel(ref_sel),
        .sys_sel(sys_sel), .rst_req(rst_req), .done_clr(done_clr),
        .cal_we(cal_we), .cal_din(cal_din), .sync_out(sync_out),
        .strobe_n(strobe_n), .is_slave(is_slave), .int_ref(int_ref),
        .sync_done(sync_done), .cal_q(cal_q), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo)
    );

    int total = 0;
    int bad   = 0;

    task automatic check_eq(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // background line driver: repeating period, optional single reset period
    int pat_per = 8;
    int pat_hi  = 0;
    bit inj     = 1'b0;

    initial begin
        sync_in = 1'b0;
        forever begin
            int p;
            int h;
            p = pat_per;
            h = pat_hi;
            if (inj) begin
                h   = 1;
                inj = 1'b0;
            end
            for (int i = 0; i < p; i++) begin
                @(negedge clk);
                sync_in = (i < h);
            end
        end
    end

    // output monitors
    int run = 0, n1 = 0, n5 = 0, nlow = 0;
    always @(negedge clk) begin
        if (!strobe_n) nlow++;
        if (sync_out) run++;
        else begin
            if (run == 1) n1++;
            else if (run == 5) n5++;
            run = 0;
        end
    end

    task automatic pulse_req();
        @(negedge clk); rst_req = 1'b1;
        @(negedge clk); rst_req = 1'b0;
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int b1, b5, bl;
        rst_n = 1'b0; ref_sel = 1'b1; sys_sel = 1'b0; rst_req = 1'b0;
        done_clr = 1'b0; cal_we = 1'b0; cal_din = 8'h00;
        repeat (4) @(negedge clk);
        check_eq("R1 reset cnt_lo", cnt_lo, 0);
        check_eq("R1 reset cnt_hi", cnt_hi, 0);
        check_eq("R8 reset strobe_n", strobe_n, 1);
        check_eq("R11 reset done", sync_done, 0);
        check_eq("R3 reset slave", is_slave, 0);
        check_eq("R3 reset int_ref", int_ref, 1);
        rst_n = 1'b1;

        // R6 sweep over period length and high time
        for (int per = 6; per <= 10; per++) begin
            for (int k = 0; k < 6; k++) begin
                int hi;
                bit valid, isref;
                hi = (k == 0) ? 0 : k + 2;
                pat_per = per;
                pat_hi  = hi;
                repeat (10 * per + 16) @(negedge clk);
                valid = (per >= 7) && (per <= 9) && (hi >= 3) && (hi <= 6) && (hi < per);
                isref = valid && (hi >= 5);
                check_eq(isref ? "R6 R2 sweep slave" : (valid ? "R6 R4 sweep slave" : "R6 R3 sweep slave"),
                         is_slave, isref);
                check_eq(isref ? "R6 R2 sweep int_ref" : (valid ? "R6 R4 sweep int_ref" : "R6 R3 sweep int_ref"),
                         int_ref, !valid);
            end
        end

        // R7 hold then loss
        pat_per = 8; pat_hi = 5;
        repeat (100) @(negedge clk);
        check_eq("R2 slave on reference", is_slave, 1);
        pat_hi = 0;
        repeat (16) @(negedge clk);
        check_eq("R7 class held", is_slave, 1);
        repeat (40) @(negedge clk);
        check_eq("R7 class lost slave", is_slave, 0);
        check_eq("R7 class lost int_ref", int_ref, 1);

        // R4 master on external clock emits reference symbols
        pat_hi = 4;
        repeat (100) @(negedge clk);
        b1 = n1; b5 = n5;
        repeat (40) @(negedge clk);
        check_eq("R4 ext slave", is_slave, 0);
        check_eq("R4 ext int_ref", int_ref, 0);
        check_eq("R4 ref symbols out", (n5 - b5) >= 4, 1);
        check_eq("R4 no reset symbols", n1 - b1, 0);

        // R13 chain input not selected
        pat_hi = 5;
        repeat (100) @(negedge clk);
        ref_sel = 1'b0;
        @(negedge clk);
        check_eq("R13 slave", is_slave, 0);
        check_eq("R13 int_ref", int_ref, 1);
        ref_sel = 1'b1;

        // R5 system clock reference ignores incoming reset symbols
        sys_sel = 1'b1;
        @(negedge clk);
        check_eq("R5 slave", is_slave, 0);
        check_eq("R5 int_ref", int_ref, 0);
        bl = nlow;
        inj = 1'b1;
        repeat (40) @(negedge clk);
        check_eq("R5 no strobe", nlow - bl, 0);
        check_eq("R5 no done", sync_done, 0);

        // R8 master reset and R1 count boundaries
        b1 = n1; bl = nlow;
        pulse_req();
        check_eq("R8 strobe low", strobe_n, 0);
        check_eq("R8 cnt cleared", cnt_lo, 0);
        check_eq("R11 done set", sync_done, 1);
        @(negedge clk);
        check_eq("R8 strobe back high", strobe_n, 1);
        repeat (6) @(negedge clk);
        check_eq("R1 cnt at 7 edges", cnt_lo, 0);
        @(negedge clk);
        check_eq("R1 cnt at 8 edges", cnt_lo, 1);
        repeat (92) @(negedge clk);
        check_eq("R1 cnt at 100 edges", cnt_lo, 12);
        check_eq("R1 cnt_hi", cnt_hi, 0);
        check_eq("R8 one reset symbol", n1 - b1, 1);
        check_eq("R8 one strobe sample", nlow - bl, 1);

        // R11 clear and set-wins
        clear_done();
        check_eq("R11 cleared", sync_done, 0);
        @(negedge clk); rst_req = 1'b1; done_clr = 1'b1;
        @(negedge clk); rst_req = 1'b0; done_clr = 1'b0;
        check_eq("R11 set wins", sync_done, 1);
        clear_done();

        // R9 slave local reset
        sys_sel = 1'b0;
        repeat (100) @(negedge clk);
        check_eq("R9 is slave", is_slave, 1);
        b1 = n1;
        pulse_req();
        check_eq("R9 strobe low", strobe_n, 0);
        check_eq("R9 cnt cleared", cnt_lo, 0);
        repeat (40) @(negedge clk);
        check_eq("R9 no reset symbol out", n1 - b1, 0);

        // R10 slave receives reset symbol
        clear_done();
        b1 = n1; bl = nlow;
        inj = 1'b1;
        repeat (40) @(negedge clk);
        check_eq("R10 one strobe", nlow - bl, 1);
        check_eq("R10 done", sync_done, 1);
        check_eq("R10 relayed", n1 - b1, 1);
        check_eq("R10 still slave", is_slave, 1);
        check_eq("R10 cnt small", cnt_lo <= 5, 1);

        // R12 trim byte
        @(negedge clk); cal_we = 1'b1; cal_din = 8'hA5;
        @(negedge clk); cal_we = 1'b0; cal_din = 8'h3C;
        check_eq("R12 loaded", cal_q, 8'hA5);
        repeat (3) @(negedge clk);
        check_eq("R12 held", cal_q, 8'hA5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule